// File: doc/BRIEF.md
# Presettable Up/Down Decade or Binary Counter

This block is a four-bit synchronous counter. A compile-time switch selects how it counts: either through the decade codes 0 to 9, or through the full binary range 0 to 15. On each rising clock edge the count steps up or down by one, but only while the active-low count enable is low. A separate direction input sets which way it steps.

A high clear input forces the count to zero at once. A high load input copies a four-bit parallel value into the count at once. Clear wins over load.

An active-low terminal flag goes low when two things are true together: the enable is low, and the count is at its last value for the current direction. This flag feeds the enable of the next more significant stage. That way, a chain of stages on one shared clock counts as one wider synchronous counter.

In decade mode, the counter may be loaded with one of the unused codes 10 to 15. From any such code it walks back into the legal range within a fixed number of clocks.

The control logic is organised around a small set of named operations, chosen once per cycle:

- **CLEAR** (clear high)
- **LOAD** (load high, clear low)
- **HOLD** (enable high)
- **UP** (enable low, direction high)
- **DOWN** (enable low, direction low)

The transitions are:

- UP and DOWN each move the count to its successor code.
- HOLD keeps the count.
- CLEAR and LOAD act without waiting for a clock edge.

Top module: `updn_counter`

## Requirements
- R1: While `clr` is high, `q` is 0 without waiting for a clock edge, whatever the other inputs are.
- R2: While `load` is high and `clr` is low, `q` equals `din` without waiting for a clock edge, and counting is suppressed.
- R3: With `clr` and `load` low and `en_n` high, `q` keeps its value across clock edges.
- R4: With `en_n` low, each rising clock edge adds one to `q` when `up` is 1 and subtracts one when `up` is 0.
- R5: The count wraps at its last value. In decade mode (`DECADE`=1), up goes from 9 to 0 and down goes from 0 to 9. In binary mode (`DECADE`=0), up goes from 15 to 0 and down goes from 0 to 15.
- R6: `tc_n` is 0 exactly when `en_n` is 0 and `q` is at the last value for the current direction. Counting up, that value is 9 in decade mode and 15 in binary mode. Counting down, it is 0. Otherwise `tc_n` is 1.
- R7: In decade mode, one up step maps the unused codes as follows: 10 goes to 11, 12 to 13, 14 to 15, and 11, 13 and 15 each go to 0.
- R8: In decade mode, one down step maps the unused codes as follows: 11 goes to 10, 13 to 12, 15 to 14, and 10, 12 and 14 each go to 9.
- R9: In decade mode, steps from a code in 0..9 stay in 0..9. From any code in 10..15, the count is back in 0..9 within 2 up steps, or within 4 down steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| clr | input | 1 | Clear to zero, active high, acts without a clock edge |
| load | input | 1 | Parallel load of `din`, active high, acts without a clock edge |
| din | input | 4 | Parallel load value |
| en_n | input | 1 | Count enable, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | 4 | Current count |
| tc_n | output | 1 | Terminal flag, active low, for cascading |

## Verification
The load property assumes that `din` is held still for as long as `load` is high. The reason is that the counter only samples the parallel value on the rising edge of `load` and on the clock edges that follow.

The hold and step properties assume that `load` and `clr` change only between clock edges and are held for whole cycles. The bench drives every input on the falling clock edge, and it changes `din` only while `load` is low, so both assumptions stay true.

// File: rtl/updn_pkg.sv
package updn_pkg;
    localparam int CW = 4;
    localparam logic [CW-1:0] DEC_TOP = CW'(9);
    localparam logic [CW-1:0] BIN_TOP = {CW{1'b1}};

    typedef enum logic [2:0] {
        OP_CLEAR,
        OP_LOAD,
        OP_HOLD,
        OP_UP,
        OP_DOWN
    } op_e;
endpackage

// File: rtl/updn_step.sv
module updn_step
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] inc,
    output logic [CW-1:0] dec
);
    generate
        if (DECADE) begin : g_dec
            // Unused codes: odd ones fall to 0 going up, even ones fall to 9 going down.
            always_comb begin
                if (cur == DEC_TOP || (cur > DEC_TOP && cur[0]))
                    inc = '0;
                else
                    inc = cur + CW'(1);
                if (cur == '0 || (cur > DEC_TOP && !cur[0]))
                    dec = DEC_TOP;
                else
                    dec = cur - CW'(1);
            end
        end else begin : g_bin
            always_comb begin
                inc = cur + CW'(1);
                dec = cur - CW'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic [CW-1:0] cur,
    input  logic          up,
    input  logic          en_n,
    output logic          tc_n
);
    localparam logic [CW-1:0] TOP = DECADE ? DEC_TOP : BIN_TOP;

    logic at_end;

    always_comb begin
        at_end = up ? (cur == TOP) : (cur == '0);
        tc_n   = !(at_end && !en_n);
    end
endmodule

// File: rtl/updn_counter.sv
module updn_counter
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] din,
    input  logic          en_n,
    input  logic          up,
    output logic [CW-1:0] q,
    output logic          tc_n
);
    op_e           op;
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt_up;
    logic [CW-1:0] nxt_dn;

    updn_step #(.DECADE(DECADE)) u_step (
        .cur (cnt),
        .inc (nxt_up),
        .dec (nxt_dn)
    );

    updn_term #(.DECADE(DECADE)) u_term (
        .cur  (cnt),
        .up   (up),
        .en_n (en_n),
        .tc_n (tc_n)
    );

    always_comb begin
        if (clr)
            op = OP_CLEAR;
        else if (load)
            op = OP_LOAD;
        else if (en_n)
            op = OP_HOLD;
        else if (up)
            op = OP_UP;
        else
            op = OP_DOWN;
    end

    always_ff @(posedge clk or posedge clr or posedge load) begin
        if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= din;
        end else begin
            unique case (op)
                OP_UP:   cnt <= nxt_up;
                OP_DOWN: cnt <= nxt_dn;
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb q = cnt;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input logic          clk,
    input logic          clr,
    input logic          load,
    input logic [CW-1:0] din,
    input logic          en_n,
    input logic          up,
    input logic [CW-1:0] q,
    input logic          tc_n
);
    localparam logic [CW-1:0] TOP = DECADE ? DEC_TOP : BIN_TOP;

    a_r1_clear_zero: assert property (@(posedge clk) clr |-> q == '0);

    a_r2_load_value: assert property (@(posedge clk) disable iff (clr)
        load |-> q == din);

    a_r3_hold: assert property (@(posedge clk) disable iff (clr)
        (!load && en_n) |=> ($stable(q) || load));

    a_r4_up_legal: assert property (@(posedge clk) disable iff (clr)
        (!load && !en_n && up && q < TOP) |=> (q == $past(q) + CW'(1) || load));

    a_r5_wrap_down: assert property (@(posedge clk) disable iff (clr)
        (!load && !en_n && !up && q == '0) |=> (q == TOP || load));

    a_r6_tc_needs_en: assert property (@(posedge clk) disable iff (clr)
        !tc_n |-> !en_n);

    generate
        if (DECADE) begin : g_dec
            a_r7_up_illegal: assert property (@(posedge clk) disable iff (clr)
                (!load && !en_n && up && q > DEC_TOP) |=> (q <= DEC_TOP || q[0] || load));

            a_r8_down_illegal: assert property (@(posedge clk) disable iff (clr)
                (!load && !en_n && !up && q > DEC_TOP) |=> (q == DEC_TOP || !q[0] || load));

            a_r9_stays_legal: assert property (@(posedge clk) disable iff (clr)
                (!load && q <= DEC_TOP) |=> (q <= DEC_TOP || load));
        end
    endgenerate
endmodule

bind updn_counter updn_counter_chk #(.DECADE(DECADE)) u_chk (
    .clk  (clk),
    .clr  (clr),
    .load (load),
    .din  (din),
    .en_n (en_n),
    .up   (up),
    .q    (q),
    .tc_n (tc_n)
);

// File: tb/updn_counter_test.sv
`timescale 1ns/1ps
module updn_counter_test;
    typedef struct packed {
        logic       clr;
        logic       load;
        logic [3:0] din;
        logic       en_n;
        logic       up;
        logic       tc_exp;
        logic [3:0] q_exp;
    } vec_t;

    // Fields: clr, load, din, en_n, up, tc_n before the edge, q after the edge.
    localparam vec_t VECS [11] = '{
        '{1'b0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 4'd0},  // R3 hold
        '{1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd1},  // R4 up
        '{1'b0, 1'b1, 4'd8, 1'b0, 1'b1, 1'b1, 4'd8},  // R2 load beats counting
        '{1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd9},  // R4 up
        '{1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd0},  // R5 R6 wrap up at 9
        '{1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 4'd0},  // R6 enable off
        '{1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R5 R6 wrap down at 0
        '{1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd8},  // R4 down
        '{1'b0, 1'b1, 4'd5, 1'b1, 1'b0, 1'b1, 4'd5},  // R2 load
        '{1'b1, 1'b1, 4'd7, 1'b0, 1'b1, 1'b1, 4'd0},  // R1 clear beats load
        '{1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd1}   // R4 up after clear
    };

    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       load = 1'b0;
    logic [3:0] din = 4'd0;
    logic       en_n = 1'b1;
    logic       up = 1'b1;
    logic [3:0] q;
    logic       tc_n;
    logic [3:0] qb;
    logic       tcb_n;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    updn_counter #(.DECADE(1'b1)) uut (
        .clk(clk), .clr(clr), .load(load), .din(din),
        .en_n(en_n), .up(up), .q(q), .tc_n(tc_n)
    );

    updn_counter #(.DECADE(1'b0)) uut_bin (
        .clk(clk), .clr(clr), .load(load), .din(din),
        .en_n(en_n), .up(up), .q(qb), .tc_n(tcb_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic preload(input logic [3:0] v);
        load = 1'b1;
        din  = v;
        tick();
        load = 1'b0;
    endtask

    initial begin : watchdog
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        tick();
        check("R1 reset q", q, 0);
        check("R6 reset tc_n", tc_n, 1);
        clr = 1'b0;

        foreach (VECS[i]) begin
            clr  = VECS[i].clr;
            load = VECS[i].load;
            din  = VECS[i].din;
            en_n = VECS[i].en_n;
            up   = VECS[i].up;
            #1;
            check("R6 table tc_n", tc_n, VECS[i].tc_exp);
            tick();
            check("R1-R5 table q", q, VECS[i].q_exp);
        end
        clr = 1'b0;
        load = 1'b0;

        // R1: clear acts between clock edges
        preload(4'd6);
        #3 clr = 1'b1;
        #1 check("R1 clear without edge", q, 0);
        @(negedge clk);
        clr = 1'b0;

        // R2: load acts between clock edges
        din = 4'd3;
        #2 load = 1'b1;
        #1 check("R2 load without edge", q, 3);
        @(negedge clk);
        load = 1'b0;

        // R3: hold over several edges
        en_n = 1'b1;
        up = 1'b1;
        tick();
        tick();
        check("R3 hold", q, 3);

        // R7 and R9 up: single step map and recovery bound
        for (int c = 10; c < 16; c++) begin
            preload(4'(c));
            en_n = 1'b0;
            up = 1'b1;
            tick();
            check("R7 up map", q, (c % 2 == 1) ? 0 : c + 1);
            tick();
            check("R9 up recovery", int'(q <= 4'd9), 1);
            en_n = 1'b1;
        end

        // R8 and R9 down: single step map and recovery bound
        for (int c = 10; c < 16; c++) begin
            preload(4'(c));
            en_n = 1'b0;
            up = 1'b0;
            tick();
            check("R8 down map", q, (c % 2 == 0) ? 9 : c - 1);
            tick();
            tick();
            tick();
            check("R9 down recovery", int'(q <= 4'd9), 1);
            en_n = 1'b1;
        end

        // R9: legal decade codes stay legal in both directions
        for (int c = 0; c < 10; c++) begin
            preload(4'(c));
            en_n = 1'b0;
            up = c[0];
            tick();
            check("R9 legal stays legal", int'(q <= 4'd9), 1);
            en_n = 1'b1;
        end

        // R4 R5 R6: binary variant in both directions
        for (int c = 0; c < 16; c++) begin
            preload(4'(c));
            en_n = 1'b0;
            up = 1'b1;
            #1 check("R6 binary up tc_n", tcb_n, (c == 15) ? 0 : 1);
            tick();
            check("R4 R5 binary up", qb, (c + 1) % 16);
            en_n = 1'b1;
            preload(4'(c));
            en_n = 1'b0;
            up = 1'b0;
            #1 check("R6 binary down tc_n", tcb_n, (c == 0) ? 0 : 1);
            tick();
            check("R4 R5 binary down", qb, (c + 15) % 16);
            en_n = 1'b1;
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule